// File: doc/BRIEF.md
# Endpoint Interrupt Status Controller

This block collects the interrupt sources of a USB device controller into one 32-bit status word and drives one interrupt request line. Each of the sixteen endpoint directions (eight endpoints, OUT and IN) owns a status bit. So do a periodic frame tick and a device-status event. Hardware event strobes set the bits. A small register port lets software clear bits, force bits on and choose which bits may raise the request line.

NAK reporting is conditional. Four qualifier inputs decide whether a transmitted NAK counts as an event. They cover the control endpoint's OUT side, its IN side, the OUT side of the other endpoints and the IN side of the other endpoints. The control endpoint's OUT bit also latches when a SETUP packet is accepted. The block has no sequencing of its own: every bit is an independent sticky flag, updated once per clock.

Top module: `epirq_ctrl`

## Requirements
- R1: Status bit 2n belongs to endpoint n OUT and bit 2n+1 to endpoint n IN, for n = 0..7. Bit 30 is the frame flag and bit 31 is the device flag. Bits 16..29 always read 0 and ignore every write.
- R2: A one-cycle pulse on `ep_done_i[k]` sets status bit k. The new value is visible on `status_o` after the next rising clock edge.
- R3: A pulse on `setup_rx_i` sets status bit 0.
- R4: `ep_nak_i[0]` sets bit 0 only while `nak_ctrl_out_en_i` is 1. `ep_nak_i[1]` sets bit 1 only while `nak_ctrl_in_en_i` is 1.
- R5: For k = 2..15, `ep_nak_i[k]` sets bit k only while `nak_gen_out_en_i` (even k) or `nak_gen_in_en_i` (odd k) is 1.
- R6: A write with `reg_sel_i` = 0 clears every status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R7: A write with `reg_sel_i` = 1 sets every status bit whose data bit is 1. Data bits of 0 have no effect. A read with selector 1 returns the status word.
- R8: A write with `reg_sel_i` = 2 loads the enable mask, which reads back on selector 2. `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R9: When a hardware event and a software clear reach the same bit in the same cycle, the bit ends up set.
- R10: After reset the status word, the enable mask and `irq_o` are all 0.
- R11: A pulse on `frame_tick_i` sets bit 30, and a pulse on `dev_evt_i` sets bit 31.
- R12: Writes with `reg_sel_i` = 3 change nothing, and reads with that selector return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_done_i | input | 16 | Per-direction strobe: active bit cleared by hardware |
| ep_nak_i | input | 16 | Per-direction strobe: NAK transmitted |
| setup_rx_i | input | 1 | SETUP packet accepted on endpoint 0 |
| frame_tick_i | input | 1 | Frame tick |
| dev_evt_i | input | 1 | Device status change |
| nak_ctrl_out_en_i | input | 1 | Qualifier: report NAKs on control OUT |
| nak_ctrl_in_en_i | input | 1 | Qualifier: report NAKs on control IN |
| nak_gen_out_en_i | input | 1 | Qualifier: report NAKs on other OUT endpoints |
| nak_gen_in_en_i | input | 1 | Qualifier: report NAKs on other IN endpoints |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 clear, 1 set, 2 enable, 3 reserved |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| status_o | output | 32 | Current status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a hardware event and a software clear landing on the same bit in the same clock. The bench first sets bit 4 through the set register. It then drives the endpoint 4 strobe in the very cycle it writes a clear that also covers bit 5, so one bit shows the priority and its neighbour shows that the clear still acts. The NAK qualifiers are swept from a vector table: each qualifier is enabled alone against a NAK on every direction, which exposes any direction routed to the wrong qualifier.

// File: rtl/epirq_pkg.sv
package epirq_pkg;
    localparam int STAT_W    = 32;
    localparam int FRAME_BIT = 30;
    localparam int DEV_BIT   = 31;

    typedef enum logic [1:0] {
        SEL_CLR  = 2'd0,
        SEL_SET  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_RSVD = 2'd3
    } regsel_e;
endpackage

// File: rtl/epirq_event_merge.sv
module epirq_event_merge
    import epirq_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_EP-1:0]   ep_done,
    input  logic [2*NUM_EP-1:0]   ep_nak,
    input  logic                  setup_rx,
    input  logic                  frame_tick,
    input  logic                  dev_evt,
    input  logic                  q_ctrl_out,
    input  logic                  q_ctrl_in,
    input  logic                  q_gen_out,
    input  logic                  q_gen_in,
    output logic [STAT_W-1:0]     hw_set
);
    localparam int EPD = 2 * NUM_EP;

    for (genvar d = 0; d < EPD; d++) begin : g_dir
        logic nak_ok;
        if (d < 2) begin : g_ctrl
            assign nak_ok = (d % 2 == 0) ? q_ctrl_out : q_ctrl_in;
        end else begin : g_gen
            assign nak_ok = (d % 2 == 0) ? q_gen_out : q_gen_in;
        end
        if (d == 0) begin : g_setup
            assign hw_set[d] = ep_done[d] | (ep_nak[d] & nak_ok) | setup_rx;
        end else begin : g_plain
            assign hw_set[d] = ep_done[d] | (ep_nak[d] & nak_ok);
        end
    end

    for (genvar g = EPD; g < FRAME_BIT; g++) begin : g_gap
        assign hw_set[g] = 1'b0;
    end

    assign hw_set[FRAME_BIT] = frame_tick;
    assign hw_set[DEV_BIT]   = dev_evt;

    // R4
    ctrl_out_nak_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_nak[0] && !q_ctrl_out && !ep_done[0] && !setup_rx) |-> !hw_set[0]);
    // R4
    ctrl_in_nak_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_nak[1] && !q_ctrl_in && !ep_done[1]) |-> !hw_set[1]);
endmodule

// File: rtl/epirq_status_reg.sv
module epirq_status_reg
    import epirq_pkg::*;
#(
    parameter logic [STAT_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] hw_set,
    input  logic [STAT_W-1:0] sw_clr,
    input  logic [STAT_W-1:0] sw_set,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] status_nx;

    always_comb begin
        status_nx = ((status & ~sw_clr) | hw_set | sw_set) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_nx;
    end

    // R9
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((status & $past(hw_set & IMPL_MASK)) == $past(hw_set & IMPL_MASK)));
    // R6
    clr_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr != '0) |=> ((status & $past(sw_clr & ~hw_set & ~sw_set)) == '0));
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set | sw_clr | sw_set) == '0) |=> $stable(status));
endmodule

// File: rtl/epirq_ctrl.sv
module epirq_ctrl
    import epirq_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_EP-1:0]   ep_done_i,
    input  logic [2*NUM_EP-1:0]   ep_nak_i,
    input  logic                  setup_rx_i,
    input  logic                  frame_tick_i,
    input  logic                  dev_evt_i,
    input  logic                  nak_ctrl_out_en_i,
    input  logic                  nak_ctrl_in_en_i,
    input  logic                  nak_gen_out_en_i,
    input  logic                  nak_gen_in_en_i,
    input  logic                  reg_wr_i,
    input  logic [1:0]            reg_sel_i,
    input  logic [STAT_W-1:0]     reg_wdata_i,
    output logic [STAT_W-1:0]     reg_rdata_o,
    output logic [STAT_W-1:0]     status_o,
    output logic                  irq_o
);
    localparam int EPD = 2 * NUM_EP;
    localparam logic [STAT_W-1:0] EP_MASK   = STAT_W'((64'd1 << EPD) - 64'd1);
    localparam logic [STAT_W-1:0] IMPL_MASK = EP_MASK
                                            | (STAT_W'(1) << FRAME_BIT)
                                            | (STAT_W'(1) << DEV_BIT);

    regsel_e           sel;
    logic [STAT_W-1:0] hw_set, sw_clr, sw_set, enable_q;

    assign sel    = regsel_e'(reg_sel_i);
    assign sw_clr = (reg_wr_i && sel == SEL_CLR) ? reg_wdata_i : '0;
    assign sw_set = (reg_wr_i && sel == SEL_SET) ? reg_wdata_i : '0;

    epirq_event_merge #(.NUM_EP(NUM_EP)) merge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ep_done    (ep_done_i),
        .ep_nak     (ep_nak_i),
        .setup_rx   (setup_rx_i),
        .frame_tick (frame_tick_i),
        .dev_evt    (dev_evt_i),
        .q_ctrl_out (nak_ctrl_out_en_i),
        .q_ctrl_in  (nak_ctrl_in_en_i),
        .q_gen_out  (nak_gen_out_en_i),
        .q_gen_in   (nak_gen_in_en_i),
        .hw_set     (hw_set)
    );

    epirq_status_reg #(.IMPL_MASK(IMPL_MASK)) stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_clr (sw_clr),
        .sw_set (sw_set),
        .status (status_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         enable_q <= '0;
        else if (reg_wr_i && sel == SEL_EN) enable_q <= reg_wdata_i & IMPL_MASK;
    end

    always_comb begin
        unique case (sel)
            SEL_CLR, SEL_SET: reg_rdata_o = status_o;
            SEL_EN:           reg_rdata_o = enable_q;
            default:          reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_o & enable_q);

    // R8
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != '0));
    // R12
    rsvd_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && sel == SEL_RSVD) |=> $stable(enable_q));
endmodule

// File: tb/epirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module epirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ep_done = '0, ep_nak = '0;
    logic        setup_rx = 0, frame_tick = 0, dev_evt = 0;
    logic [3:0]  qual = '0;
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, status;
    logic        irq;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    epirq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ep_done_i(ep_done), .ep_nak_i(ep_nak),
        .setup_rx_i(setup_rx), .frame_tick_i(frame_tick), .dev_evt_i(dev_evt),
        .nak_ctrl_out_en_i(qual[0]), .nak_ctrl_in_en_i(qual[1]),
        .nak_gen_out_en_i(qual[2]), .nak_gen_in_en_i(qual[3]),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .status_o(status), .irq_o(irq)
    );

    // {done, nak, setup, frame, dev, qual[3:0], expected status}
    localparam int NV = 12;
    localparam logic [70:0] VEC [NV] = '{
        {16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 32'h0000_0001}, // R2
        {16'h8002, 16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 32'h0000_8002}, // R2
        {16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'b0000, 32'h0000_0001}, // R3
        {16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0, 4'b0000, 32'h0000_0000}, // R4
        {16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0, 4'b0001, 32'h0000_0001}, // R4
        {16'h0000, 16'h0002, 1'b0, 1'b0, 1'b0, 4'b0001, 32'h0000_0000}, // R4
        {16'h0000, 16'h0002, 1'b0, 1'b0, 1'b0, 4'b0010, 32'h0000_0002}, // R4
        {16'h0000, 16'hFFFC, 1'b0, 1'b0, 1'b0, 4'b0100, 32'h0000_5554}, // R5
        {16'h0000, 16'hFFFC, 1'b0, 1'b0, 1'b0, 4'b1000, 32'h0000_AAA8}, // R5
        {16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'b0011, 32'h0000_0003}, // R5
        {16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000, 32'h4000_0000}, // R11
        {16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'b0000, 32'h8000_0000}  // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 status", status, 32'h0);
        check("R10 irq", {31'd0, irq}, 32'h0);
        reg_sel = 2'd2; #0.1;
        check("R10 enable", reg_rdata, 32'h0);
        rst_n = 1'b1;
        tick();

        for (int v = 0; v < NV; v++) begin
            reg_write(2'd0, 32'hFFFF_FFFF);
            {ep_done, ep_nak, setup_rx, frame_tick, dev_evt, qual} = VEC[v][70:32];
            tick();
            ep_done = '0; ep_nak = '0; setup_rx = 0; frame_tick = 0; dev_evt = 0; qual = '0;
            check($sformatf("R2-vector %0d (R4 R5 R11)", v), status, VEC[v][31:0]);
        end

        // R1 unimplemented bits through the set register; R7 readback
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_write(2'd1, 32'hFFFF_FFFF);
        check("R1 mask", status, 32'hC000_FFFF);
        reg_sel = 2'd1; #0.1;
        check("R7 readback", reg_rdata, 32'hC000_FFFF);

        // R6 partial clear, zeros inert
        reg_write(2'd0, 32'h8000_00F0);
        check("R6 partial clear", status, 32'h4000_FF0F);
        reg_write(2'd0, 32'h0);
        check("R6 zero write", status, 32'h4000_FF0F);

        // R7 set with zeros inert
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_write(2'd1, 32'h0);
        check("R7 zero write", status, 32'h0);
        reg_write(2'd1, 32'h0000_0300);
        check("R7 set", status, 32'h0000_0300);

        // R8 enable and irq
        check("R8 irq off", {31'd0, irq}, 32'h0);
        reg_write(2'd2, 32'h0000_0200);
        reg_sel = 2'd2; #0.1;
        check("R8 enable readback", reg_rdata, 32'h0000_0200);
        check("R8 irq on", {31'd0, irq}, 32'h1);
        reg_write(2'd0, 32'h0000_0200);
        check("R8 irq after clear", {31'd0, irq}, 32'h0);

        // R12 reserved selector
        reg_write(2'd3, 32'hFFFF_FFFF);
        check("R12 status", status, 32'h0000_0100);
        reg_sel = 2'd2; #0.1;
        check("R12 enable", reg_rdata, 32'h0000_0200);
        reg_sel = 2'd3; #0.1;
        check("R12 read", reg_rdata, 32'h0);

        // R9 hardware set beats same-cycle clear
        reg_write(2'd1, 32'h0000_0030);
        ep_done = 16'h0010;
        reg_write(2'd0, 32'h0000_0030);
        ep_done = '0;
        check("R9 set wins", status, 32'h0000_0110);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule